// File: doc/BRIEF.md
# Serial ADC Host Reader

This block is the host side of a serial link to an 8-bit successive-approximation converter with two analogue inputs. One pulse on the request input starts a read. The block pulls chip select low and generates the serial clock from the system clock through a programmable divider. It sends a start bit followed by a 2-bit channel/mode code, then releases the data line so that the converter's output may share the wire. It then collects the result twice: once most-significant bit first and once least-significant bit first.

When the read is over the block raises chip select and presents the first copy on `result` with a one-cycle `done` strobe. `mismatch` shows whether the two copies disagreed. The request side has no back-pressure queue. A request is accepted only while `busy` is low, and a request seen while `busy` is high is dropped without effect. The result side is a plain strobe with no ready input. `result` and `mismatch` hold their values until the next read completes, so a consumer may read them at any time after `done`.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `sdi_oe` is 0, `busy` is 0 and `done` is 0.
- R2: A request seen while `busy` is 0 drives `cs_n` low and `busy` high on the next clock. The block latches `req_sel` and `req_div` at that point.
- R3: Each half period of `sclk` lasts `req_div`+1 system clocks. `sclk` begins low, and chip select is low for exactly 38 half periods, 19 of them high. `sclk` stays low whenever `cs_n` is high.
- R4: Before rising edges 1, 2 and 3 of `sclk`, `sdi` carries 1 (start), then `req_sel[1]`, then `req_sel[0]`. `sdi_oe` is 1 from the fall of `cs_n` until falling edge 3 and is 0 afterwards.
- R5: The converter output is sampled at falling edges of `sclk`. Falling edge 4 is a settling slot and is not captured. Falling edges 5 to 12 deliver result bits 7 down to 0, and these bits form `result`.
- R6: The least-significant-first copy takes bit 0 from falling edge 12, as a shared bit, and bits 1 to 7 from falling edges 13 to 19.
- R7: `cs_n` returns high at falling edge 19. On the following clock `done` is 1 for exactly one cycle.
- R8: `mismatch` is 1 together with `done` when the two copies differ, and 0 when they agree. `result` and `mismatch` hold until the next `done`.
- R9: `busy` stays high, and `cs_n` stays high, for at least two `sclk` half periods after a read ends before a new read can begin.
- R10: A request that arrives while `busy` is 1 is ignored. No extra read starts and no extra `done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request strobe |
| req_sel | input | 2 | Channel/mode code sent after the start bit, bit 1 first |
| req_div | input | DIV_W | Half period of `sclk` minus one, in system clocks |
| busy | output | 1 | High from acceptance until the idle gap ends |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdi | output | 1 | Serial data to the converter |
| sdi_oe | output | 1 | Drive enable for `sdi` on a shared line |
| sdo | input | 1 | Serial data from the converter |
| done | output | 1 | One-cycle completion strobe |
| result | output | RES_W | Result taken from the most-significant-first copy |
| mismatch | output | 1 | The two captured copies differ |

## Verification
The hardest case to reach from the ports is a real disagreement between the two copies of the result, because a well-behaved converter always sends them consistent. The converter model in the bench can be told to flip one bit only in its least-significant-first stream. It also drives the settling slot with the inverse of the next bit, so a capture taken one edge early or late corrupts the value. A second case that is hard to reach is a request arriving mid-read, which the bench raises deliberately while chip select is low.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP} rd_state_e;
  // start bit plus two select bits
  localparam int unsigned ADDR_BITS  = 3;
  localparam int unsigned GAP_HALVES = 2;
endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int RES_W = 8,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             fall_stb,
  input  logic [IDX_W-1:0] fall_idx,
  input  logic             sdo,
  output logic [RES_W-1:0] msb_word,
  output logic [RES_W-1:0] lsb_word
);
  import adc_rd_pkg::*;
  localparam logic [IDX_W-1:0] MSB_FIRST = IDX_W'(ADDR_BITS + 2);
  localparam logic [IDX_W-1:0] MSB_LAST  = IDX_W'(ADDR_BITS + 1 + RES_W);
  localparam logic [IDX_W-1:0] LSB_LAST  = IDX_W'(ADDR_BITS + 2*RES_W);

  logic take_msb, take_lsb;
  assign take_msb = fall_stb && (fall_idx >= MSB_FIRST) && (fall_idx <= MSB_LAST);
  assign take_lsb = fall_stb && (fall_idx >= MSB_LAST)  && (fall_idx <= LSB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_word <= '0;
      lsb_word <= '0;
    end else if (clear) begin
      msb_word <= '0;
      lsb_word <= '0;
    end else begin
      if (take_msb) msb_word <= {msb_word[RES_W-2:0], sdo};
      if (take_lsb) lsb_word <= {sdo, lsb_word[RES_W-1:1]};
    end
  end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int RES_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_sel,
  input  logic [DIV_W-1:0] req_div,
  output logic             busy,
  output logic             cs_n,
  output logic             sclk,
  output logic             sdi,
  output logic             sdi_oe,
  input  logic             sdo,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             mismatch
);
  import adc_rd_pkg::*;
  localparam int LAST_FALL = ADDR_BITS + 2*RES_W;
  localparam int LAST_T    = 2*LAST_FALL;
  localparam int T_W       = $clog2(LAST_T + 1);
  localparam logic [T_W-1:0] LAST_T_V  = T_W'(LAST_T);
  localparam logic [T_W-1:0] ADDR_T_V  = T_W'(2*ADDR_BITS);

  rd_state_e        state;
  logic [T_W-1:0]   t_cnt, t_nxt;
  logic [1:0]       sel_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       gap_cnt;
  logic             fin_q, tick, fall_stb, start;
  logic [T_W-1:0]   fall_idx;
  logic [RES_W-1:0] msb_word, lsb_word;

  assign busy     = (state != ST_IDLE);
  assign start    = (state == ST_IDLE) && req_valid;
  assign t_nxt    = t_cnt + 1'b1;
  assign fall_stb = (state == ST_XFER) && tick && sclk;
  assign fall_idx = {1'b0, t_nxt[T_W-1:1]};

  // address phase: slot 0 start, slot 1 sel[1], slot 2 sel[0]
  assign sdi_oe = (state == ST_XFER) && (t_cnt < ADDR_T_V);
  always_comb begin
    unique case (t_cnt[T_W-1:1])
      T_W'(0):  sdi = sdi_oe;
      T_W'(1):  sdi = sdi_oe && sel_q[1];
      default:  sdi = sdi_oe && sel_q[0];
    endcase
  end

  adc_rd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_div(div_q), .tick(tick)
  );

  adc_rd_capture #(.RES_W(RES_W), .IDX_W(T_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clear(start), .fall_stb(fall_stb),
    .fall_idx(fall_idx), .sdo(sdo), .msb_word(msb_word), .lsb_word(lsb_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      t_cnt    <= '0;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      sel_q    <= '0;
      div_q    <= '0;
      gap_cnt  <= '0;
      fin_q    <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      mismatch <= 1'b0;
    end else begin
      done  <= 1'b0;
      fin_q <= 1'b0;
      if (fin_q) begin
        done     <= 1'b1;
        result   <= msb_word;
        mismatch <= (msb_word != lsb_word);
      end
      unique case (state)
        ST_IDLE: if (req_valid) begin
          state <= ST_XFER;
          cs_n  <= 1'b0;
          sclk  <= 1'b0;
          t_cnt <= '0;
          sel_q <= req_sel;
          div_q <= req_div;
        end
        ST_XFER: if (tick) begin
          t_cnt <= t_nxt;
          sclk  <= ~sclk;
          if (t_nxt == LAST_T_V) begin
            state   <= ST_GAP;
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
            gap_cnt <= '0;
            fin_q   <= 1'b1;
          end
        end
        ST_GAP: if (tick) begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == 2'(GAP_HALVES - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic cs_n,
  input logic sclk,
  input logic sdi_oe,
  input logic done
);
  a_r3_sclk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r4_oe_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sdi_oe |-> !cs_n);
  a_r2_start_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> (!cs_n && busy));
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(!busy));
  a_r7_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> done);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_gap_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> (busy && cs_n));
endmodule

bind adc_serial_reader adc_serial_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .cs_n(cs_n), .sclk(sclk), .sdi_oe(sdi_oe), .done(done)
);

// File: tb/adc_serial_reader_tb.sv
module adc_serial_reader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_sel = '0;
  logic [7:0] req_div = '0;
  logic busy, cs_n, sclk, sdi, sdi_oe, done, mismatch;
  logic sdo;
  logic [7:0] result;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  adc_serial_reader u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_div(req_div), .busy(busy), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdi_oe(sdi_oe), .sdo(sdo), .done(done), .result(result), .mismatch(mismatch)
  );

  // converter model
  logic [7:0] m_val = '0;
  logic       m_bad = 1'b0;
  logic [1:0] m_sel = '0;
  logic       m_start = 1'b0;
  int         mf = 0;
  int         mr = 0;
  logic       sdo_m = 1'b1;
  assign sdo = sdo_m;

  always @(negedge cs_n) begin mf = 0; mr = 0; sdo_m = 1'b1; end
  always @(posedge sclk) if (!cs_n) begin
    mr = mr + 1;
    if (mr == 1) m_start = sdi;
    if (mr == 2) m_sel[1] = sdi;
    if (mr == 3) m_sel[0] = sdi;
  end
  always @(negedge sclk) if (!cs_n) begin
    logic [7:0] img;
    img = m_bad ? (m_val ^ 8'h08) : m_val;
    mf = mf + 1;
    if (mf == 3)                   sdo_m = ~m_val[7];
    else if (mf >= 4 && mf <= 11)  sdo_m = m_val[11-mf];
    else if (mf >= 12 && mf <= 18) sdo_m = img[mf-11];
    else                           sdo_m = 1'b1;
  end

  typedef struct { logic [7:0] val; logic [1:0] sel; logic bad; } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: timing counters and scoreboard
  int cs_hi_run = 0, last_gap = 0, low_cnt = 0, sh_cnt = 0, oe_bad = 0;
  always @(negedge clk) if (rst_n) begin
    if (cs_n) cs_hi_run++;
    else begin
      if (cs_hi_run != 0) begin last_gap = cs_hi_run; low_cnt = 0; sh_cnt = 0; end
      cs_hi_run = 0;
      low_cnt++;
      if (sclk) sh_cnt++;
      if (sdi_oe != (mf < 3)) oe_bad++;
    end
    if (done) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(result == e.val, "R5 result", int'(result), int'(e.val));
        chk(mismatch == e.bad, "R8 mismatch", int'(mismatch), int'(e.bad));
        chk(m_start && (m_sel == e.sel), "R4 start/select", int'({m_start, m_sel}), int'({1'b1, e.sel}));
      end
    end
  end

  int prev_div = -1;

  task automatic start_read(input logic [7:0] v, input logic [1:0] s, input logic [7:0] d, input bit bad);
    m_val = v; m_bad = bad;
    exp_q.push_back('{v, s, bad});
    @(negedge clk); req_valid = 1'b1; req_sel = s; req_div = d;
    @(negedge clk); req_valid = 1'b0;
    chk(!cs_n && busy, "R2 read start", int'({cs_n, busy}), 1);
    @(negedge clk);
    if (prev_div >= 0)
      chk(last_gap >= 2*(prev_div+1), "R9 idle gap", last_gap, 2*(prev_div+1));
  endtask

  task automatic finish_read(input logic [7:0] d);
    while (!done) @(negedge clk);
    chk(low_cnt == 38*(int'(d)+1), "R3 cs low length", low_cnt, 38*(int'(d)+1));
    chk(sh_cnt == 19*(int'(d)+1), "R3 sclk high length", sh_cnt, 19*(int'(d)+1));
    chk(oe_bad == 0, "R4 sdi_oe window", oe_bad, 0);
    oe_bad = 0;
    @(negedge clk);
    chk(!done, "R7 done one cycle", int'(done), 0);
    while (busy) @(negedge clk);
    prev_div = int'(d);
  endtask

  task automatic do_read(input logic [7:0] v, input logic [1:0] s, input logic [7:0] d, input bit bad);
    start_read(v, s, d, bad);
    finish_read(d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !sdi_oe && !busy && !done, "R1 reset state",
        int'({cs_n, sclk, sdi_oe, busy, done}), 16);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_read(8'hA5, 2'd2, 8'd0, 1'b0);   // R5 R6 agreeing copies
    do_read(8'h5A, 2'd1, 8'd1, 1'b0);
    do_read(8'h00, 2'd0, 8'd3, 1'b0);
    do_read(8'hFF, 2'd3, 8'd0, 1'b0);
    do_read(8'h01, 2'd2, 8'd1, 1'b0);
    do_read(8'h80, 2'd1, 8'd2, 1'b0);
    do_read(8'hA5, 2'd0, 8'd1, 1'b1);   // R8 R6 disagreeing copies
    do_read(8'h3C, 2'd3, 8'd0, 1'b0);   // R8 flag clears on agreement
    // R10: request during a read
    start_read(8'h69, 2'd1, 8'd1, 1'b0);
    repeat (30) @(negedge clk);
    req_valid = 1'b1; req_sel = 2'd2;
    @(negedge clk); req_valid = 1'b0;
    finish_read(8'd1);
    repeat (10) @(negedge clk);
    chk(cs_n && !busy && exp_q.size() == 0, "R10 request ignored",
        int'({cs_n, busy}), 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule